// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block is the command front end of a NOR-style flash memory. It watches host write cycles, each an address and a 16-bit data word, and decodes the low byte of the data as a command code. It follows the multi-cycle sequences for word program, buffered program, factory streaming program and block erase. It keeps a read-mode register that decides what every later host read returns: array data, the status byte, identifier words or query (CFI) words.

Towards an abstract program/erase engine it issues one-cycle start, buffer-word, suspend and resume pulses, together with the operation type, address, data and buffer word count. The engine answers with a done pulse and a fail flag. Array contents, identifier values and the query table come from small stubs inside the read path. The set of commands the block accepts narrows while an operation runs and widens again during a suspend.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset the read mode is array, no engine pulse is active, the status byte is 0x80 and a read at address A returns A[15:0] ^ 0x5A5A.
- R2: Codes 0xFF, 0x70, 0x90 and 0x98 (data bits 7:0) select the array, status, identifier and query read modes. In status mode a read returns {8'h00, status}. In identifier mode address bit 0 picks maker word 0x00A7 (bit 0 = 0) or part word 0x2271 (bit 0 = 1). In query mode addresses 0x10, 0x11 and 0x12 return 0x0051, 0x0052 and 0x0059, and every other address returns 0.
- R3: A command is decoded once per rising edge of wr_stb. A strobe held high for many cycles counts as one write.
- R4: 0x40 switches the read mode to status. The next write produces a one-cycle eng_start with eng_op = 0 (word) and that write's address and data on eng_addr and eng_data. Status bit 7 (ready) stays 0 until done.
- R5: 0xE8 switches to status mode. The next write gives the word count minus one: a value of 512 or more is a sequence error. Each of the following N writes gives a buf_wr pulse with its address and data. Then 0xD0 starts eng_op = 1 (buffered) with eng_count = N-1, and any other code is a sequence error.
- R6: 0x80 followed by 0xD0 starts eng_op = 3 (factory). Until eng_done, every write gives only a buf_wr pulse and changes neither the read mode nor the status.
- R7: 0x20 followed by 0xD0 starts eng_op = 2 (erase) at the confirm write's address. Any other second code is a sequence error with no start.
- R8: While an operation runs, only 0x70 (status mode) and 0xB0 (suspend) have any effect. 0xFF, 0x50, 0x40 and all other codes are ignored.
- R9: 0xB0 during a run gives eng_suspend and sets ready (bit 7), plus bit 6 for an erase or bit 2 for a program. While suspended, 0xFF, 0x70, 0x90, 0x98 and 0x50 work. 0xD0 gives eng_resume, selects status mode and clears bits 7, 6 and 2.
- R10: eng_done sets ready, and the read mode stays status until 0xFF is written. eng_fail sampled with eng_done sets bit 5 for an erase and bit 4 for any program.
- R11: An unknown code in idle, or a wrong second cycle, sets bits 5 and 4 and returns the decoder to idle, where the next write is decoded normally. An unknown code in idle leaves the read mode unchanged.
- R12: 0x50 clears bits 5 and 4 when written in idle or while suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Host write strobe, acted on at its rising edge |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 16 | Host write data; bits 7:0 carry the command code |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | 16 | Read data chosen by the read mode |
| eng_start | output | 1 | One-cycle operation start request |
| eng_op | output | 2 | Operation type: 0 word, 1 buffered, 2 erase, 3 factory |
| eng_addr | output | ADDR_W | Address of the write that caused the last pulse |
| eng_data | output | 16 | Data of the write that caused the last pulse |
| eng_count | output | CNT_W | Buffered word count minus one |
| buf_wr | output | 1 | One-cycle buffer word pulse |
| eng_suspend | output | 1 | One-cycle suspend request |
| eng_resume | output | 1 | One-cycle resume request |
| eng_done | input | 1 | Engine finished the current operation |
| eng_fail | input | 1 | Engine reports failure, valid with eng_done |

## Verification
The bench holds the strobe high across several clocks after a setup code. A level-sensitive decoder would then take the held word as the program data and start the engine too early. It writes 0xFF and 0x50 during a run, to catch a decoder that leaves status mode or clears errors while busy. It streams command-looking words in factory mode, to catch one that still decodes them. It checks that the read mode stays in status after completion until 0xFF is written. It also checks the buffer-count overflow at exactly 512 and bad confirm codes after each kind of setup, which a loose decoder would either accept or leave stuck in a setup state.

// File: rtl/fcf_pkg.sv
package fcf_pkg;

   localparam logic [7:0] C_READ_ARRAY  = 8'hFF;
   localparam logic [7:0] C_READ_STATUS = 8'h70;
   localparam logic [7:0] C_READ_IDENT  = 8'h90;
   localparam logic [7:0] C_READ_CFI    = 8'h98;
   localparam logic [7:0] C_CLEAR       = 8'h50;
   localparam logic [7:0] C_WORD_SETUP  = 8'h40;
   localparam logic [7:0] C_BUF_SETUP   = 8'hE8;
   localparam logic [7:0] C_FAC_SETUP   = 8'h80;
   localparam logic [7:0] C_ERASE_SETUP = 8'h20;
   localparam logic [7:0] C_CONFIRM     = 8'hD0;
   localparam logic [7:0] C_SUSPEND     = 8'hB0;

   typedef enum logic [1:0] {
      RM_ARRAY  = 2'd0,
      RM_STATUS = 2'd1,
      RM_IDENT  = 2'd2,
      RM_CFI    = 2'd3
   } rmode_e;

   typedef enum logic [1:0] {
      OP_WORD    = 2'd0,
      OP_BUFFER  = 2'd1,
      OP_ERASE   = 2'd2,
      OP_FACTORY = 2'd3
   } op_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_WP_DATA,
      S_BUF_CNT,
      S_BUF_LOAD,
      S_BUF_CONF,
      S_FAC_CONF,
      S_ERS_CONF,
      S_BUSY,
      S_SUSP,
      S_FACTORY
   } seq_e;

endpackage

// File: rtl/fcf_stb_edge.sv
module fcf_stb_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   output logic ev
);
   logic stb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) stb_q <= 1'b0;
      else        stb_q <= stb;
   end

   assign ev = stb & ~stb_q;
endmodule

// File: rtl/fcf_seq.sv
module fcf_seq
   import fcf_pkg::*;
#(
   parameter  int ADDR_W    = 16,
   parameter  int BUF_WORDS = 512,
   localparam int CNT_W     = $clog2(BUF_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [15:0]       cmd_data,
   input  logic              eng_done,
   output rmode_e            rmode,
   output logic              busy,
   output logic              suspended,
   output logic              op_erase,
   output logic              start_o,
   output logic              bufwr_o,
   output logic              suspend_o,
   output logic              resume_o,
   output op_e               op_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [15:0]       data_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              seq_err,
   output logic              clear,
   output logic              done_evt
);
   seq_e             st, st_n;
   rmode_e           mode_n;
   op_e              op_n;
   logic [CNT_W-1:0] left, left_n, cnt_n;
   logic             start_n, bufwr_n, susp_n, res_n, xfer_n;
   logic [7:0]       code;
   logic             cnt_ok;

   assign code   = cmd_data[7:0];
   assign cnt_ok = ({16'd0, cmd_data} < 32'(BUF_WORDS));

   always_comb begin
      st_n     = st;
      mode_n   = rmode;
      op_n     = op_o;
      left_n   = left;
      cnt_n    = cnt_o;
      start_n  = 1'b0;
      bufwr_n  = 1'b0;
      susp_n   = 1'b0;
      res_n    = 1'b0;
      xfer_n   = 1'b0;
      seq_err  = 1'b0;
      clear    = 1'b0;
      done_evt = 1'b0;
      unique case (st)
         S_IDLE: if (ev) begin
            unique case (code)
               C_READ_ARRAY:  mode_n = RM_ARRAY;
               C_READ_STATUS: mode_n = RM_STATUS;
               C_READ_IDENT:  mode_n = RM_IDENT;
               C_READ_CFI:    mode_n = RM_CFI;
               C_CLEAR:       clear  = 1'b1;
               C_WORD_SETUP:  begin st_n = S_WP_DATA;  mode_n = RM_STATUS; end
               C_BUF_SETUP:   begin st_n = S_BUF_CNT;  mode_n = RM_STATUS; end
               C_FAC_SETUP:   begin st_n = S_FAC_CONF; mode_n = RM_STATUS; end
               C_ERASE_SETUP: begin st_n = S_ERS_CONF; mode_n = RM_STATUS; end
               default:       seq_err = 1'b1;
            endcase
         end
         S_WP_DATA: if (ev) begin
            start_n = 1'b1;
            op_n    = OP_WORD;
            xfer_n  = 1'b1;
            st_n    = S_BUSY;
         end
         S_BUF_CNT: if (ev) begin
            if (cnt_ok) begin
               cnt_n  = cmd_data[CNT_W-1:0];
               left_n = cmd_data[CNT_W-1:0];
               st_n   = S_BUF_LOAD;
            end else begin
               seq_err = 1'b1;
               st_n    = S_IDLE;
            end
         end
         S_BUF_LOAD: if (ev) begin
            bufwr_n = 1'b1;
            xfer_n  = 1'b1;
            if (left == '0) st_n = S_BUF_CONF;
            else            left_n = left - 1'b1;
         end
         S_BUF_CONF, S_FAC_CONF, S_ERS_CONF: if (ev) begin
            if (code == C_CONFIRM) begin
               start_n = 1'b1;
               xfer_n  = 1'b1;
               if (st == S_BUF_CONF)      begin op_n = OP_BUFFER;  st_n = S_BUSY;    end
               else if (st == S_FAC_CONF) begin op_n = OP_FACTORY; st_n = S_FACTORY; end
               else                       begin op_n = OP_ERASE;   st_n = S_BUSY;    end
            end else begin
               seq_err = 1'b1;
               st_n    = S_IDLE;
            end
         end
         S_BUSY: begin
            if (eng_done) begin
               done_evt = 1'b1;
               st_n     = S_IDLE;
            end else if (ev) begin
               if (code == C_READ_STATUS) mode_n = RM_STATUS;
               else if (code == C_SUSPEND) begin
                  susp_n = 1'b1;
                  st_n   = S_SUSP;
               end
            end
         end
         S_SUSP: if (ev) begin
            unique case (code)
               C_READ_ARRAY:  mode_n = RM_ARRAY;
               C_READ_STATUS: mode_n = RM_STATUS;
               C_READ_IDENT:  mode_n = RM_IDENT;
               C_READ_CFI:    mode_n = RM_CFI;
               C_CLEAR:       clear  = 1'b1;
               C_CONFIRM:     begin res_n = 1'b1; st_n = S_BUSY; mode_n = RM_STATUS; end
               default:       ;
            endcase
         end
         S_FACTORY: begin
            if (eng_done) begin
               done_evt = 1'b1;
               st_n     = S_IDLE;
            end else if (ev) begin
               bufwr_n = 1'b1;
               xfer_n  = 1'b1;
            end
         end
         default: st_n = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         rmode     <= RM_ARRAY;
         op_o      <= OP_WORD;
         left      <= '0;
         cnt_o     <= '0;
         start_o   <= 1'b0;
         bufwr_o   <= 1'b0;
         suspend_o <= 1'b0;
         resume_o  <= 1'b0;
         addr_o    <= '0;
         data_o    <= '0;
      end else begin
         st        <= st_n;
         rmode     <= mode_n;
         op_o      <= op_n;
         left      <= left_n;
         cnt_o     <= cnt_n;
         start_o   <= start_n;
         bufwr_o   <= bufwr_n;
         suspend_o <= susp_n;
         resume_o  <= res_n;
         if (xfer_n) begin
            addr_o <= cmd_addr;
            data_o <= cmd_data;
         end
      end
   end

   assign busy      = (st == S_BUSY) || (st == S_FACTORY);
   assign suspended = (st == S_SUSP);
   assign op_erase  = (op_o == OP_ERASE);
endmodule

// File: rtl/fcf_status.sv
module fcf_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       busy,
   input  logic       suspended,
   input  logic       op_erase,
   input  logic       seq_err,
   input  logic       clear,
   input  logic       done_evt,
   input  logic       eng_fail,
   output logic [7:0] sr
);
   logic prog_err, ers_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_err <= 1'b0;
         ers_err  <= 1'b0;
      end else if (seq_err) begin
         prog_err <= 1'b1;
         ers_err  <= 1'b1;
      end else if (done_evt && eng_fail) begin
         if (op_erase) ers_err  <= 1'b1;
         else          prog_err <= 1'b1;
      end else if (clear) begin
         prog_err <= 1'b0;
         ers_err  <= 1'b0;
      end
   end

   assign sr = {~busy, suspended & op_erase, ers_err, prog_err,
                1'b0, suspended & ~op_erase, 2'b00};
endmodule

// File: rtl/fcf_read_mux.sv
module fcf_read_mux
   import fcf_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter logic [15:0] ID_MAKER = 16'h00A7,
   parameter logic [15:0] ID_PART  = 16'h2271
) (
   input  rmode_e            rmode,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        sr,
   output logic [15:0]       rd_data
);
   logic [15:0] array_word, ident_word, cfi_word;

   assign array_word = rd_addr[15:0] ^ 16'h5A5A;
   assign ident_word = rd_addr[0] ? ID_PART : ID_MAKER;

   always_comb begin
      if      (rd_addr == ADDR_W'(16'h0010)) cfi_word = 16'h0051;
      else if (rd_addr == ADDR_W'(16'h0011)) cfi_word = 16'h0052;
      else if (rd_addr == ADDR_W'(16'h0012)) cfi_word = 16'h0059;
      else                                   cfi_word = 16'h0000;
   end

   always_comb begin
      unique case (rmode)
         RM_ARRAY:  rd_data = array_word;
         RM_STATUS: rd_data = {8'h00, sr};
         RM_IDENT:  rd_data = ident_word;
         RM_CFI:    rd_data = cfi_word;
         default:   rd_data = 16'h0000;
      endcase
   end
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
   import fcf_pkg::*;
#(
   parameter  int          ADDR_W    = 16,
   parameter  int          BUF_WORDS = 512,
   parameter  bit          REG_READ  = 1'b0,
   parameter  logic [15:0] ID_MAKER  = 16'h00A7,
   parameter  logic [15:0] ID_PART   = 16'h2271,
   localparam int          CNT_W     = $clog2(BUF_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [15:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [15:0]       rd_data,
   output logic              eng_start,
   output logic [1:0]        eng_op,
   output logic [ADDR_W-1:0] eng_addr,
   output logic [15:0]       eng_data,
   output logic [CNT_W-1:0]  eng_count,
   output logic              buf_wr,
   output logic              eng_suspend,
   output logic              eng_resume,
   input  logic              eng_done,
   input  logic              eng_fail
);
   if (ADDR_W < 16 || ADDR_W > 32) begin : g_chk_aw
      $error("flash_cmd_front: ADDR_W must lie in 16..32");
   end
   if (BUF_WORDS < 2 || BUF_WORDS > 65536) begin : g_chk_buf
      $error("flash_cmd_front: BUF_WORDS must lie in 2..65536");
   end

   logic        wr_ev;
   rmode_e      read_mode;
   op_e         op_w;
   logic        busy_w, susp_w, erase_w;
   logic        seq_err_w, clear_w, done_w;
   logic [7:0]  status_byte;
   logic [15:0] mux_data;

   fcf_stb_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (wr_stb),
      .ev    (wr_ev)
   );

   fcf_seq #(
      .ADDR_W    (ADDR_W),
      .BUF_WORDS (BUF_WORDS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (wr_ev),
      .cmd_addr  (wr_addr),
      .cmd_data  (wr_data),
      .eng_done  (eng_done),
      .rmode     (read_mode),
      .busy      (busy_w),
      .suspended (susp_w),
      .op_erase  (erase_w),
      .start_o   (eng_start),
      .bufwr_o   (buf_wr),
      .suspend_o (eng_suspend),
      .resume_o  (eng_resume),
      .op_o      (op_w),
      .addr_o    (eng_addr),
      .data_o    (eng_data),
      .cnt_o     (eng_count),
      .seq_err   (seq_err_w),
      .clear     (clear_w),
      .done_evt  (done_w)
   );

   assign eng_op = op_w;

   fcf_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy_w),
      .suspended (susp_w),
      .op_erase  (erase_w),
      .seq_err   (seq_err_w),
      .clear     (clear_w),
      .done_evt  (done_w),
      .eng_fail  (eng_fail),
      .sr        (status_byte)
   );

   fcf_read_mux #(
      .ADDR_W   (ADDR_W),
      .ID_MAKER (ID_MAKER),
      .ID_PART  (ID_PART)
   ) u_rmux (
      .rmode   (read_mode),
      .rd_addr (rd_addr),
      .sr      (status_byte),
      .rd_data (mux_data)
   );

   if (REG_READ) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) rd_data <= 16'h0000;
         else        rd_data <= mux_data;
      end
   end else begin : g_rd_comb
      assign rd_data = mux_data;
   end
endmodule

// File: rtl/fcf_checker.sv
module fcf_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       eng_start,
   input logic       buf_wr,
   input logic       eng_suspend,
   input logic       eng_resume,
   input logic [7:0] sr,
   input logic [1:0] rmode,
   input logic       seq_err,
   input logic       clear,
   input logic       done_evt,
   input logic       eng_fail
);
   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({eng_start, buf_wr, eng_suspend, eng_resume}));  // R3

   AST_START_IN_STATUS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> rmode == 2'd1);  // R4

   AST_START_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> !sr[7]);  // R4

   AST_SEQ_ERR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> sr[5] && sr[4]);  // R11

   AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      clear && !seq_err |=> !sr[5] && !sr[4]);  // R12

   AST_SUSPEND_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      eng_suspend |-> sr[7] && (sr[6] || sr[2]));  // R9

   AST_RESUME_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      eng_resume |-> !sr[7] && !sr[6] && !sr[2]);  // R9

   AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt |=> sr[7]);  // R10

   AST_FAIL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt && eng_fail |=> sr[5] || sr[4]);  // R10
endmodule

bind flash_cmd_front fcf_checker u_fcf_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .eng_start   (eng_start),
   .buf_wr      (buf_wr),
   .eng_suspend (eng_suspend),
   .eng_resume  (eng_resume),
   .sr          (status_byte),
   .rmode       (read_mode),
   .seq_err     (seq_err_w),
   .clear       (clear_w),
   .done_evt    (done_w),
   .eng_fail    (eng_fail)
);

// File: tb/flash_cmd_front_bench.sv
`timescale 1ns/1ps
module flash_cmd_front_bench;
   localparam int AW = 16;
   localparam int CW = 9;
   localparam logic [15:0] MAKER = 16'h00A7;
   localparam logic [15:0] PART  = 16'h2271;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [15:0]   wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [15:0]   rd_data;
   logic          eng_start;
   logic [1:0]    eng_op;
   logic [AW-1:0] eng_addr;
   logic [15:0]   eng_data;
   logic [CW-1:0] eng_count;
   logic          buf_wr, eng_suspend, eng_resume;
   logic          eng_done = 1'b0;
   logic          eng_fail = 1'b0;

   int  nchk = 0;
   int  nfail = 0;
   bit  finished = 1'b0;

   logic          s_start, s_bufwr, s_susp, s_res;
   logic [1:0]    s_op;
   logic [AW-1:0] s_addr;
   logic [15:0]   s_data;

   always #2 clk = ~clk;

   flash_cmd_front u_flash_cmd_front (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .eng_start(eng_start), .eng_op(eng_op),
      .eng_addr(eng_addr), .eng_data(eng_data), .eng_count(eng_count), .buf_wr(buf_wr),
      .eng_suspend(eng_suspend), .eng_resume(eng_resume), .eng_done(eng_done),
      .eng_fail(eng_fail)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_read(input int mode, input logic [15:0] a,
                                            input logic [7:0] sr);
      case (mode)
         0: return a ^ 16'h5A5A;
         1: return {8'h00, sr};
         2: return a[0] ? PART : MAKER;
         default: begin
            if (a == 16'h0010) return 16'h0051;
            if (a == 16'h0011) return 16'h0052;
            if (a == 16'h0012) return 16'h0059;
            return 16'h0000;
         end
      endcase
   endfunction

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_addr = a; wr_data = d; wr_stb = 1'b1;
      @(negedge clk);
      s_start = eng_start; s_bufwr = buf_wr; s_susp = eng_suspend; s_res = eng_resume;
      s_op = eng_op; s_addr = eng_addr; s_data = eng_data;
      wr_stb = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd(input logic [15:0] a, output logic [15:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic expect_sr(input string tag, input logic [7:0] e);
      logic [15:0] v;
      rd(16'h0000, v);
      chk(tag, {16'h0, v}, {24'h0, e});
   endtask

   task automatic finish_op(input logic f);
      @(negedge clk);
      eng_done = 1'b1; eng_fail = f;
      @(negedge clk);
      eng_done = 1'b0; eng_fail = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog: run hung, actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      int          starts;
      int          mode;
      logic        perr, eerr;
      logic [7:0]  mcmd [4];
      logic [7:0]  bad [6];
      mcmd = '{8'hFF, 8'h70, 8'h90, 8'h98};
      bad  = '{8'h00, 8'h11, 8'hD0, 8'hB0, 8'h33, 8'hC7};
      void'($urandom(32'd7));

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 no pulses", {28'h0, eng_start, buf_wr, eng_suspend, eng_resume}, 32'h0);
      rd(16'h1234, v);
      chk("R1 array read after reset", {16'h0, v}, {16'h0, 16'h1234 ^ 16'h5A5A});
      wr(16'h0, 16'h0070);
      expect_sr("R1 status after reset", 8'h80);

      // R2, R11, R12: random read-mode, unknown-code and clear mix
      mode = 1; perr = 1'b0; eerr = 1'b0;
      for (int i = 0; i < 60; i++) begin
         int          k;
         logic [7:0]  c;
         logic [15:0] a;
         k = int'($urandom_range(0, 9));
         if (k < 4) begin c = mcmd[k]; mode = k; end
         else if (k < 6) begin c = bad[$urandom_range(0, 5)]; perr = 1'b1; eerr = 1'b1; end
         else if (k == 6) begin c = 8'h50; perr = 1'b0; eerr = 1'b0; end
         else begin k = int'($urandom_range(0, 3)); c = mcmd[k]; mode = k; end
         wr(16'($urandom), {8'h00, c});
         if ($urandom_range(0, 1) == 1) a = 16'h000F + 16'($urandom_range(0, 4));
         else                           a = 16'($urandom);
         rd(a, v);
         chk("R2 random mode read", {16'h0, v},
             {16'h0, exp_read(mode, a, {1'b1, 1'b0, eerr, perr, 4'b0000})});
      end
      wr(16'h0, 16'h0050);
      wr(16'h0, 16'h0070);
      expect_sr("R12 clear after random", 8'h80);

      // R3: held strobe counts once
      @(negedge clk);
      wr_addr = 16'h0; wr_data = 16'h0040; wr_stb = 1'b1;
      starts = 0;
      repeat (5) begin
         @(negedge clk);
         if (eng_start) starts++;
      end
      wr_stb = 1'b0;
      @(negedge clk);
      chk("R3 held strobe gives no start", starts, 0);

      // R4: word program
      wr(16'h0300, 16'hBEEF);
      chk("R4 start", {31'h0, s_start}, 1);
      chk("R4 op word", {30'h0, s_op}, 0);
      chk("R4 addr", {16'h0, s_addr}, 32'h0300);
      chk("R4 data", {16'h0, s_data}, 32'hBEEF);
      expect_sr("R4 busy status", 8'h00);

      // R8: ignored while busy
      wr(16'h0, 16'h00FF);
      expect_sr("R8 FF ignored while busy", 8'h00);
      wr(16'h0, 16'h0040);
      chk("R8 setup ignored while busy", {31'h0, s_start}, 0);

      // R10: completion
      finish_op(1'b0);
      expect_sr("R10 ready after done, status mode kept", 8'h80);
      wr(16'h0, 16'h00FF);
      rd(16'h0042, v);
      chk("R10 array after FF", {16'h0, v}, {16'h0, 16'h0042 ^ 16'h5A5A});
      wr(16'h0, 16'h0040);
      wr(16'h0010, 16'h1111);
      finish_op(1'b1);
      expect_sr("R10 program fail bit4", 8'h90);
      wr(16'h0, 16'h0050);
      expect_sr("R12 clear in idle", 8'h80);

      // R7, R9: erase with suspend and resume
      wr(16'h0, 16'h0020);
      wr(16'h0700, 16'h00D0);
      chk("R7 erase start", {31'h0, s_start}, 1);
      chk("R7 op erase", {30'h0, s_op}, 2);
      chk("R7 erase addr", {16'h0, s_addr}, 32'h0700);
      expect_sr("R7 busy", 8'h00);
      wr(16'h0, 16'h00B0);
      chk("R9 suspend pulse", {31'h0, s_susp}, 1);
      expect_sr("R9 erase suspended", 8'hC0);
      wr(16'h0, 16'h00FF);
      rd(16'h0055, v);
      chk("R9 array during suspend", {16'h0, v}, {16'h0, 16'h0055 ^ 16'h5A5A});
      wr(16'h0, 16'h0070);
      wr(16'h0, 16'h00D0);
      chk("R9 resume pulse", {31'h0, s_res}, 1);
      expect_sr("R9 busy after resume", 8'h00);
      finish_op(1'b1);
      expect_sr("R10 erase fail bit5", 8'hA0);
      wr(16'h0, 16'h0050);

      // R7, R11: bad erase confirm
      wr(16'h0, 16'h0020);
      wr(16'h0, 16'h00FF);
      chk("R7 no start on bad confirm", {31'h0, s_start}, 0);
      expect_sr("R11 sequence error bits", 8'hB0);
      wr(16'h0, 16'h0090);
      rd(16'h0001, v);
      chk("R11 decoding resumes after error", {16'h0, v}, {16'h0, PART});
      wr(16'h0, 16'h0050);
      wr(16'h0, 16'h0070);

      // R9: program suspend
      wr(16'h0, 16'h0040);
      wr(16'h0020, 16'h2222);
      wr(16'h0, 16'h00B0);
      expect_sr("R9 program suspended", 8'h84);
      wr(16'h0, 16'h00D0);
      chk("R9 program resume", {31'h0, s_res}, 1);
      finish_op(1'b0);
      expect_sr("R9 done after resume", 8'h80);

      // R5: buffered program
      wr(16'h0, 16'h00E8);
      wr(16'h0100, 16'h0002);
      for (int j = 0; j < 3; j++) begin
         wr(16'h0100 + 16'(j), 16'hA000 + 16'(j));
         chk("R5 buffer word pulse", {31'h0, s_bufwr}, 1);
         chk("R5 buffer word addr", {16'h0, s_addr}, {16'h0, 16'h0100 + 16'(j)});
         chk("R5 buffer word data", {16'h0, s_data}, {16'h0, 16'hA000 + 16'(j)});
      end
      wr(16'h0100, 16'h00D0);
      chk("R5 buffered start", {31'h0, s_start}, 1);
      chk("R5 op buffered", {30'h0, s_op}, 1);
      chk("R5 count", {23'h0, eng_count}, 2);
      finish_op(1'b0);
      expect_sr("R5 done", 8'h80);
      wr(16'h0, 16'h00E8);
      wr(16'h0, 16'd512);
      expect_sr("R5 count overflow", 8'hB0);
      wr(16'h0, 16'h0050);
      wr(16'h0, 16'h00E8);
      wr(16'h0, 16'h0000);
      wr(16'h0005, 16'h1234);
      chk("R5 single word pulse", {31'h0, s_bufwr}, 1);
      wr(16'h0, 16'h00FF);
      chk("R5 no start on bad confirm", {31'h0, s_start}, 0);
      expect_sr("R5 bad confirm error", 8'hB0);
      wr(16'h0, 16'h0050);

      // R6: factory streaming
      wr(16'h0, 16'h0080);
      wr(16'h0, 16'h00D0);
      chk("R6 factory start", {31'h0, s_start}, 1);
      chk("R6 op factory", {30'h0, s_op}, 3);
      expect_sr("R6 busy", 8'h00);
      wr(16'h0009, 16'h00FF);
      chk("R6 FF streamed as data", {31'h0, s_bufwr}, 1);
      chk("R6 no start while streaming", {31'h0, s_start}, 0);
      expect_sr("R6 mode unchanged", 8'h00);
      wr(16'h0, 16'h0033);
      expect_sr("R6 unknown code no error", 8'h00);
      finish_op(1'b0);
      expect_sr("R6 done", 8'h80);
      wr(16'h0, 16'h0080);
      wr(16'h0, 16'h0040);
      chk("R11 factory bad confirm", {31'h0, s_start}, 0);
      expect_sr("R11 factory error bits", 8'hB0);

      // R8: clear ignored while busy
      wr(16'h0, 16'h0040);
      wr(16'h0044, 16'h4444);
      expect_sr("R8 errors kept busy", 8'h30);
      wr(16'h0, 16'h0050);
      expect_sr("R8 clear ignored while busy", 8'h30);
      finish_op(1'b0);
      wr(16'h0, 16'h0050);
      expect_sr("R12 clear after run", 8'h80);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule